// File: doc/BRIEF.md
# DDR Burst-of-Two Synchronous SRAM

This block is a synthesizable, small-depth model of a double-data-rate synchronous SRAM front end whose every access moves exactly two data words. Command and address are sampled on rising edges of the input clock K. Write data arrives twice per K cycle: once on the K rising edge and once on the rising edge of its complement K#. Read data is returned on both rising edges of an output clock pair C/C#. When the output clock pair is not used, the read data is returned on both rising edges of K/K# instead. Read and write data share a single bidirectional bus. The design drives that bus only while read words are being presented.

A one-bit burst counter selects the word order. With narrow words (8 or 9 bits), each address names a pair and the burst always starts at word 0. With wide words (18 or 36 bits), each address names a single word and the burst starts there. The second word is the other member of the same pair, which is the address with its LSB inverted. A new command may be issued on one K edge and not on the next. A load on that following edge is ignored and flagged.

Top module: `ddr2b_top`

## Requirements
- R1: Every accepted command moves exactly two data words. A write stores both words and a read presents both words in sequence.
- R2: A command is sampled on a rising K edge when `ld_n` is 0, with `rw_n` = 1 meaning read and `rw_n` = 0 meaning write. After an accepted command, the next K edge never accepts one.
- R3: For a write, the first word is taken from `dq` on the same K edge as the command. The second word is taken on the following rising K# edge. A read issued afterwards returns both words.
- R4: The first read word appears on `dq` after the rising output-clock# edge that comes 1.5 K periods after the command edge. The second word appears after the next rising output-clock edge, 2 K periods after the command. With `USE_C` = 0, the output clock pair is K/K#.
- R5: In the narrow configuration (`DW` <= 9), address `a` selects the word pair {a,0},{a,1}. The burst always starts at word {a,0}.
- R6: In the wide configuration (`DW` > 9), address `a` selects word `a` first and word `a` XOR 1 second, for both writes and reads.
- R7: `q_oe` is 1 exactly while a read word is presented and the block drives `dq` only then. `q_oe` is 0 during writes and falls half a K period after the second read word.
- R8: `echo_p` and `echo_n` follow the output clock and its complement, which are C/C# or K/K# depending on `USE_C`.
- R9: A load (`ld_n` = 0) on the K edge just after an accepted command is ignored, leaving memory unchanged. `proto_err` is then 1 for the following K cycle only.
- R10: While `rst` is held over a K edge, no command is pending, and after it `proto_err` and `q_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Input clock K |
| clk_kn | input | 1 | Input clock K# (complement of K) |
| clk_c | input | 1 | Output clock C (used when USE_C = 1) |
| clk_cn | input | 1 | Output clock C# (used when USE_C = 1) |
| rst | input | 1 | Synchronous active-high reset |
| ld_n | input | 1 | Active-low command load |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Access address |
| dq | inout | DW | Shared write/read data bus |
| q_oe | output | 1 | High while read data is driven on dq |
| echo_p | output | 1 | Echo of the output clock |
| echo_n | output | 1 | Echo of the output clock complement |
| proto_err | output | 1 | Load seen on the off-cycle K edge |

## Verification
Two instances run the same stimulus side by side: an 18-bit wide one clocked by C/C#, and an 8-bit narrow one running from K/K#. First, every even address is written and all sixteen addresses are read back. This tells apart the wide LSB-start ordering on odd versus even addresses from the narrow pair-from-zero ordering. Then the odd addresses are overwritten and everything is read again, which shows whether a wide write touches the right pair member. An off-cycle load is placed between two accesses to separate an ignored command from an accepted one, and the echo outputs are sampled in both clock phases.

// File: rtl/ddr2b_pkg.sv
`timescale 1ns/1ps
package ddr2b_pkg;
  typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;

  // Row address bits of each bank: wide words pair on the address LSB,
  // narrow words pair internally so the full address is the row.
  function automatic int row_bits(input int aw, input int dw);
    return (dw > 9) ? aw - 1 : aw;
  endfunction
endpackage

// File: rtl/ddr2b_cmd.sv
`timescale 1ns/1ps
module ddr2b_cmd #(
  parameter int AW  = 4,
  parameter int DW  = 18,
  parameter int RAW = 3
) (
  input  logic           clk_k,
  input  logic           clk_kn,
  input  logic           rst,
  input  logic           ld_n,
  input  logic           rw_n,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  din,
  output logic           acc,
  output logic           off,
  output logic           perr,
  output logic           wr_en,
  output logic           rd_req,
  output logic [RAW-1:0] row_q,
  output logic           start_q,
  output logic [DW-1:0]  w0_q,
  output logic [DW-1:0]  w1_q
);
  import ddr2b_pkg::*;

  logic [RAW-1:0] row;
  logic           start;
  logic           is_rd;

  // Burst counter start: wide words load it from the address LSB.
  generate
    if (DW > 9) begin : g_wide
      assign row   = addr[AW-1:1];
      assign start = addr[0];
    end else begin : g_narrow
      assign row   = addr;
      assign start = 1'b0;
    end
  endgenerate

  assign is_rd = (op_e'(rw_n) == OP_READ);
  assign acc   = !ld_n && !off;

  always_ff @(posedge clk_k) begin
    if (rst) begin
      off    <= 1'b0;
      perr   <= 1'b0;
      wr_en  <= 1'b0;
      rd_req <= 1'b0;
    end else begin
      off    <= acc;
      perr   <= !ld_n && off;
      wr_en  <= acc && !is_rd;
      rd_req <= acc && is_rd;
    end
  end

  always_ff @(posedge clk_k) begin
    if (acc) begin
      row_q   <= row;
      start_q <= start;
      w0_q    <= din;
    end
  end

  // Second write beat on the complementary edge.
  always_ff @(posedge clk_kn) begin
    w1_q <= din;
  end
endmodule

// File: rtl/ddr2b_bank.sv
`timescale 1ns/1ps
module ddr2b_bank #(
  parameter int DW  = 18,
  parameter int RAW = 3
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam int DEPTH = 1 << RAW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ddr2b_oreg.sv
`timescale 1ns/1ps
module ddr2b_oreg #(
  parameter int DW = 18
) (
  input  logic          clk_k,
  input  logic          clk_o,
  input  logic          clk_on,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          start_q,
  input  logic [DW-1:0] b0,
  input  logic [DW-1:0] b1,
  output logic [DW-1:0] q,
  output logic          oe
);
  logic          rd_v, sel;
  logic          v_n, v_p;
  logic [DW-1:0] q_n, hold1, q_p;

  always_ff @(posedge clk_k) begin
    if (rst) rd_v <= 1'b0;
    else     rd_v <= rd_req;
    sel <= start_q;
  end

  // First beat and a copy of the second on the complement edge.
  always_ff @(posedge clk_on) begin
    if (rst) v_n <= 1'b0;
    else     v_n <= rd_v;
    q_n   <= sel ? b1 : b0;
    hold1 <= sel ? b0 : b1;
  end

  always_ff @(posedge clk_o) begin
    if (rst) v_p <= 1'b0;
    else     v_p <= v_n;
    q_p <= hold1;
  end

  assign q  = clk_o ? q_p : q_n;
  assign oe = clk_o ? v_p : v_n;
endmodule

// File: rtl/ddr2b_top.sv
`timescale 1ns/1ps
module ddr2b_top #(
  parameter int DW    = 18,
  parameter int AW    = 4,
  parameter bit USE_C = 1'b1
) (
  input  logic          clk_k,
  input  logic          clk_kn,
  input  logic          clk_c,
  input  logic          clk_cn,
  input  logic          rst,
  input  logic          ld_n,
  input  logic          rw_n,
  input  logic [AW-1:0] addr,
  inout  wire  [DW-1:0] dq,
  output logic          q_oe,
  output logic          echo_p,
  output logic          echo_n,
  output logic          proto_err
);
  localparam int RAW = ddr2b_pkg::row_bits(AW, DW);

  logic           cmd_acc, cmd_off;
  logic           wr_en, rd_req, start_q;
  logic [RAW-1:0] row_q;
  logic [DW-1:0]  w0_q, w1_q, q_int;
  logic [DW-1:0]  bank_rd [2];
  logic           oclk, oclk_n;

  generate
    if (USE_C) begin : g_cclk
      assign oclk   = clk_c;
      assign oclk_n = clk_cn;
    end else begin : g_kclk
      logic unused_oclk;
      assign unused_oclk = clk_c ^ clk_cn;
      assign oclk   = clk_k;
      assign oclk_n = clk_kn;
    end
  endgenerate

  ddr2b_cmd #(.AW(AW), .DW(DW), .RAW(RAW)) u_cmd (
    .clk_k(clk_k), .clk_kn(clk_kn), .rst(rst), .ld_n(ld_n), .rw_n(rw_n),
    .addr(addr), .din(dq), .acc(cmd_acc), .off(cmd_off), .perr(proto_err),
    .wr_en(wr_en), .rd_req(rd_req), .row_q(row_q), .start_q(start_q),
    .w0_q(w0_q), .w1_q(w1_q)
  );

  // Bank b holds the pair member whose word-index LSB equals b.
  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DW-1:0] wd;
      assign wd = (start_q == b[0]) ? w0_q : w1_q;
      ddr2b_bank #(.DW(DW), .RAW(RAW)) u_bank (
        .clk(clk_k), .we(wr_en), .waddr(row_q), .wdata(wd),
        .raddr(row_q), .rdata(bank_rd[b])
      );
    end
  endgenerate

  ddr2b_oreg #(.DW(DW)) u_oreg (
    .clk_k(clk_k), .clk_o(oclk), .clk_on(oclk_n), .rst(rst),
    .rd_req(rd_req), .start_q(start_q), .b0(bank_rd[0]), .b1(bank_rd[1]),
    .q(q_int), .oe(q_oe)
  );

  assign dq     = q_oe ? q_int : {DW{1'bz}};
  assign echo_p = oclk;
  assign echo_n = oclk_n;
endmodule

// File: rtl/ddr2b_chk.sv
`timescale 1ns/1ps
module ddr2b_chk (
  input logic clk_k,
  input logic rst,
  input logic ld_n,
  input logic rw_n,
  input logic acc,
  input logic off,
  input logic proto_err,
  input logic wr_en,
  input logic rd_req
);
  assert_no_back_to_back_R2: assert property (@(posedge clk_k) disable iff (rst)
    acc |=> !acc);

  assert_offcycle_flag_R9: assert property (@(posedge clk_k) disable iff (rst)
    (!ld_n && off) |=> proto_err);

  assert_err_only_offcycle_R9: assert property (@(posedge clk_k) disable iff (rst)
    proto_err |-> $past(off && !ld_n));

  assert_write_commit_R3: assert property (@(posedge clk_k) disable iff (rst)
    wr_en |-> $past(acc && !rw_n));

  assert_read_issue_R4: assert property (@(posedge clk_k) disable iff (rst)
    rd_req |-> $past(acc && rw_n));
endmodule

bind ddr2b_top ddr2b_chk u_chk (
  .clk_k(clk_k), .rst(rst), .ld_n(ld_n), .rw_n(rw_n), .acc(cmd_acc),
  .off(cmd_off), .proto_err(proto_err), .wr_en(wr_en), .rd_req(rd_req)
);

// File: tb/sim_ddr2b_top.sv
`timescale 1ns/1ps
module sim_ddr2b_top;
  logic k = 1'b0;
  logic rst = 1'b1, ld_n = 1'b1, rw_n = 1'b1, drv = 1'b0;
  logic [3:0]  addr = '0;
  logic [17:0] wd0 = '0;
  logic [7:0]  wd1 = '0;
  wire  [17:0] dq0;
  wire  [7:0]  dq1;
  logic oe0, oe1, ep0, en0, ep1, en1, pe0, pe1;
  logic [17:0] refw [16];
  logic [7:0]  refn [32];
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 k = ~k;  // 250 MHz

  assign dq0 = drv ? wd0 : 18'bz;
  assign dq1 = drv ? wd1 : 8'bz;

  ddr2b_top #(.DW(18), .AW(4), .USE_C(1'b1)) u0 (
    .clk_k(k), .clk_kn(~k), .clk_c(k), .clk_cn(~k), .rst(rst), .ld_n(ld_n),
    .rw_n(rw_n), .addr(addr), .dq(dq0), .q_oe(oe0), .echo_p(ep0),
    .echo_n(en0), .proto_err(pe0));

  ddr2b_top #(.DW(8), .AW(4), .USE_C(1'b0)) u1 (
    .clk_k(k), .clk_kn(~k), .clk_c(1'b0), .clk_cn(1'b1), .rst(rst), .ld_n(ld_n),
    .rw_n(rw_n), .addr(addr), .dq(dq1), .q_oe(oe1), .echo_p(ep1),
    .echo_n(en1), .proto_err(pe1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [17:0] x0, input logic [17:0] x1,
                          input logic [7:0] n0, input logic [7:0] n1);
    @(posedge k); #1;
    ld_n = 0; rw_n = 0; addr = a; wd0 = x0; wd1 = n0; drv = 1;
    @(posedge k); #1;
    ld_n = 1; wd0 = x1; wd1 = n1;
    chk("R7 oe low during write (wide)", {31'd0, oe0}, 32'd0);
    chk("R7 oe low during write (narrow)", {31'd0, oe1}, 32'd0);
    @(posedge k); #1;
    drv = 0;
    refw[a] = x0; refw[a ^ 4'd1] = x1;
    refn[{a, 1'b0}] = n0; refn[{a, 1'b1}] = n1;
  endtask

  task automatic do_read(input logic [3:0] a);
    @(posedge k); #1;
    ld_n = 0; rw_n = 1; addr = a;
    @(posedge k); #1;
    ld_n = 1;
    #6;
    chk("R4 oe on first beat", {30'd0, oe0, oe1}, 32'd3);
    chk("R6 wide first word = addr", {14'd0, dq0}, {14'd0, refw[a]});
    chk("R5 narrow first word = pair word 0", {24'd0, dq1}, {24'd0, refn[{a, 1'b0}]});
    #2;
    chk("R1 oe on second beat", {30'd0, oe0, oe1}, 32'd3);
    chk("R6 wide second word = addr^1", {14'd0, dq0}, {14'd0, refw[a ^ 4'd1]});
    chk("R5 narrow second word = pair word 1", {24'd0, dq1}, {24'd0, refn[{a, 1'b1}]});
    #2;
    chk("R7 oe released after burst", {30'd0, oe0, oe1}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge k);
    #1;
    chk("R10 reset proto_err", {30'd0, pe0, pe1}, 32'd0);
    chk("R10 reset oe", {30'd0, oe0, oe1}, 32'd0);
    rst = 0;
    @(posedge k); #1;
    chk("R10 idle after reset", {28'd0, pe0, pe1, oe0, oe1}, 32'd0);
    // R8: echoes follow the output clock in both phases
    chk("R8 echo while K high", {28'd0, ep0, en0, ep1, en1}, 32'b1010);
    #2;
    chk("R8 echo while K low", {28'd0, ep0, en0, ep1, en1}, 32'b0101);

    // Pass 0: write even addresses, read every address
    for (int a = 0; a < 16; a += 2)
      do_write(4'(a), 18'(a * 4099 + 3), 18'(a * 263 + 'h2A5), 8'(a * 37 + 1), 8'(a * 53 + 200));
    for (int a = 0; a < 16; a++) do_read(4'(a));
    // Pass 1: overwrite odd addresses, read every address again (R3, R6)
    for (int a = 1; a < 16; a += 2)
      do_write(4'(a), 18'(a * 517 + 91), 18'(a * 1031 + 7), 8'(a * 11 + 5), 8'(a * 7 + 100));
    for (int a = 15; a >= 0; a--) do_read(4'(a));

    // R9: load on the off-cycle edge is ignored and flagged
    @(posedge k); #1;
    ld_n = 0; rw_n = 0; addr = 4'd2; wd0 = 18'h1ABCD; wd1 = 8'hA1; drv = 1;
    @(posedge k); #1;
    chk("R9 no flag on accepted command", {30'd0, pe0, pe1}, 32'd0);
    addr = 4'd9; wd0 = 18'h2F00F; wd1 = 8'h5B;  // ld_n still low
    @(posedge k); #1;
    chk("R9 off-cycle load flagged", {30'd0, pe0, pe1}, 32'd3);
    ld_n = 1; drv = 0;
    refw[2] = 18'h1ABCD; refw[3] = 18'h2F00F;
    refn[{4'd2, 1'b0}] = 8'hA1; refn[{4'd2, 1'b1}] = 8'h5B;
    @(posedge k); #1;
    chk("R9 flag lasts one cycle", {30'd0, pe0, pe1}, 32'd0);
    do_read(4'd9);   // unchanged by ignored load
    do_read(4'd8);
    do_read(4'd2);
    do_read(4'd3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule